// File: doc/BRIEF.md
# Priority Service Request Scheduler

This block arbitrates among sixteen channels that compete for one shared execution engine. Each channel holds up to four pending service reasons. Three of them are raised by single-cycle event strobes: a link from another channel, a timer match and an input capture. The fourth is a host-service request that software sets through a small write port. Software also uses that write port to give each channel a priority: high, middle or low. A channel with no priority assigned is disabled.

A grant can only be issued while the engine reports that it is idle. The scheduler walks a fixed seven-slot pattern of priority levels and skips any level that has no eligible request, so no grant opportunity is wasted and low-priority channels always get a turn. Within the selected level the lowest-numbered channel wins. The grant carries the channel number and the reasons that were served. Those reasons are cleared in the same edge.

Top module: `svc_sched`

## Requirements
- R1: After synchronous reset, `grant_valid` is low and every channel's priority is 00 (disabled). A request made before any priority is written produces no grant.
- R2: A grant appears on the outputs only in the cycle after a rising edge at which `engine_idle` was high. Pending requests are held, ungranted, while `engine_idle` is low. `grant_valid` is high for one cycle per grant.
- R3: The priority code is 2 bits: 00 disabled, 01 low, 10 middle, 11 high. A channel coded 00 never receives a grant, even when it has pending requests.
- R4: Levels are served in the repeating slot order high, middle, high, low, high, middle, high, starting at the first slot after reset. A slot whose level has no eligible request is skipped to the next slot in the same cycle. After a grant, the pattern continues from the slot after the one used.
- R5: Among eligible channels of the selected level, the lowest channel number wins.
- R6: `grant_reason` reports every reason the winning channel had pending before the granting edge. The bit positions are: bit 0 host-service, bit 1 link, bit 2 match, bit 3 capture.
- R7: A grant clears only the reasons it reports. A reason that arrives for the same channel at the granting edge stays pending and is served later.
- R8: A host-service bit is set by a write with `hreq_we` high for channel `hreq_ch`. It stays set until that channel is granted, no matter how long the engine stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_we | input | 1 | Priority write strobe |
| prio_ch | input | 4 | Channel addressed by a priority write |
| prio_val | input | 2 | Priority code (00 off, 01 low, 10 middle, 11 high) |
| hreq_we | input | 1 | Host-service request write strobe |
| hreq_ch | input | 4 | Channel that receives the host-service request |
| link_set | input | 16 | Per-channel link request strobes |
| match_set | input | 16 | Per-channel match request strobes |
| capture_set | input | 16 | Per-channel capture request strobes |
| engine_idle | input | 1 | Engine can accept a new channel |
| grant_valid | output | 1 | Grant pulse |
| grant_ch | output | 4 | Granted channel number |
| grant_reason | output | 4 | Reasons served by the grant |

## Verification
Two things can touch the same channel's request bits at one clock edge: a grant clearing them, and a new request setting them. The bench provokes this in two ways. It raises a capture strobe at the edge where that channel's match is granted, and it issues a host-service write at the edge where another reason of the same channel is granted. Each case is judged by checking two grants in a row: the first must report only the older reason, and the second must report only the newly arrived one.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NCH      = 16;
    localparam int NSRC     = 4;
    localparam int SEQ_LEN  = 7;
    localparam int SLOT_W   = $clog2(SEQ_LEN);

    // reason bit positions
    localparam int RSN_HOST = 0;
    localparam int RSN_LINK = 1;
    localparam int RSN_MTCH = 2;
    localparam int RSN_CAPT = 3;

    typedef logic [NSRC-1:0] reason_t;

    typedef enum logic [1:0] {
        PRIO_OFF = 2'b00,
        PRIO_LO  = 2'b01,
        PRIO_MID = 2'b10,
        PRIO_HI  = 2'b11
    } prio_e;

    // level visited in each slot: H M H L H M H
    function automatic prio_e slot_level(input logic [SLOT_W-1:0] s);
        case (s)
            3'd1, 3'd5: return PRIO_MID;
            3'd3:       return PRIO_LO;
            default:    return PRIO_HI;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] slot_add(input logic [SLOT_W-1:0] s, input int k);
        int t;
        t = int'(s) + k;
        if (t >= SEQ_LEN) t = t - SEQ_LEN;
        return SLOT_W'(t);
    endfunction

endpackage

// File: rtl/sched_prio_bank.sv
module sched_prio_bank
    import sched_pkg::*;
#(
    parameter int N_CH = NCH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [CW-1:0]         wch,
    input  logic [1:0]            wval,
    output logic [N_CH-1:0][1:0]  prio_q
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[c] <= PRIO_OFF;
            else if (we && (wch == CW'(c)))
                prio_q[c] <= wval;
        end
    end

endmodule

// File: rtl/sched_req_bank.sv
module sched_req_bank
    import sched_pkg::*;
#(
    parameter int N_CH = NCH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hreq_we,
    input  logic [CW-1:0]            hreq_ch,
    input  logic [N_CH-1:0]          link_set,
    input  logic [N_CH-1:0]          match_set,
    input  logic [N_CH-1:0]          capture_set,
    input  logic                     clr_en,
    input  logic [CW-1:0]            clr_ch,
    input  reason_t                  clr_mask,
    output logic [N_CH-1:0][NSRC-1:0] pend_q,
    output logic [N_CH-1:0][NSRC-1:0] new_req
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        reason_t kill;

        always_comb begin
            new_req[c]           = '0;
            new_req[c][RSN_HOST] = hreq_we && (hreq_ch == CW'(c));
            new_req[c][RSN_LINK] = link_set[c];
            new_req[c][RSN_MTCH] = match_set[c];
            new_req[c][RSN_CAPT] = capture_set[c];
            kill = (clr_en && (clr_ch == CW'(c))) ? clr_mask : '0;
        end

        // set wins over clear: arrivals at the granting edge survive
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[c] <= '0;
            else
                pend_q[c] <= (pend_q[c] & ~kill) | new_req[c];
        end
    end

endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter
    import sched_pkg::*;
#(
    parameter int N_CH = NCH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      engine_idle,
    input  logic [N_CH-1:0][1:0]      prio_q,
    input  logic [N_CH-1:0][NSRC-1:0] pend_q,
    output logic                      pick_valid,
    output logic [CW-1:0]             pick_ch
);

    logic [3:0][N_CH-1:0] lvl_mask;
    logic [SLOT_W-1:0]    slot_q;
    logic [SLOT_W-1:0]    win_slot;
    prio_e                win_lvl;
    logic                 found;

    always_comb begin
        lvl_mask = '0;
        for (int c = 0; c < N_CH; c++)
            if (pend_q[c] != '0) lvl_mask[prio_q[c]][c] = 1'b1;

        found    = 1'b0;
        win_slot = slot_q;
        win_lvl  = PRIO_OFF;
        for (int k = 0; k < SEQ_LEN; k++) begin
            if (!found && (|lvl_mask[slot_level(slot_add(slot_q, k))])) begin
                found    = 1'b1;
                win_slot = slot_add(slot_q, k);
                win_lvl  = slot_level(win_slot);
            end
        end
    end

    // lowest channel number within the chosen level
    always_comb begin
        logic hit;
        hit     = 1'b0;
        pick_ch = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (!hit && lvl_mask[win_lvl][c]) begin
                hit     = 1'b1;
                pick_ch = CW'(c);
            end
        end
    end

    assign pick_valid = found && engine_idle;

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (pick_valid)
            slot_q <= slot_add(win_slot, 1);
    end

endmodule

// File: rtl/svc_sched.sv
module svc_sched
    import sched_pkg::*;
#(
    parameter int N_CH = NCH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prio_we,
    input  logic [CW-1:0]    prio_ch,
    input  logic [1:0]       prio_val,
    input  logic             hreq_we,
    input  logic [CW-1:0]    hreq_ch,
    input  logic [N_CH-1:0]  link_set,
    input  logic [N_CH-1:0]  match_set,
    input  logic [N_CH-1:0]  capture_set,
    input  logic             engine_idle,
    output logic             grant_valid,
    output logic [CW-1:0]    grant_ch,
    output logic [NSRC-1:0]  grant_reason
);

    logic [N_CH-1:0][1:0]      prio_q;
    logic [N_CH-1:0][NSRC-1:0] pend_q;
    logic [N_CH-1:0][NSRC-1:0] new_req;
    logic                      pick_valid;
    logic [CW-1:0]             pick_ch;
    reason_t                   pick_reason;

    sched_prio_bank #(.N_CH(N_CH)) u_prio (
        .clk    (clk),
        .rst    (rst),
        .we     (prio_we),
        .wch    (prio_ch),
        .wval   (prio_val),
        .prio_q (prio_q)
    );

    sched_req_bank #(.N_CH(N_CH)) u_req (
        .clk         (clk),
        .rst         (rst),
        .hreq_we     (hreq_we),
        .hreq_ch     (hreq_ch),
        .link_set    (link_set),
        .match_set   (match_set),
        .capture_set (capture_set),
        .clr_en      (pick_valid),
        .clr_ch      (pick_ch),
        .clr_mask    (pick_reason),
        .pend_q      (pend_q),
        .new_req     (new_req)
    );

    sched_arbiter #(.N_CH(N_CH)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .engine_idle (engine_idle),
        .prio_q      (prio_q),
        .pend_q      (pend_q),
        .pick_valid  (pick_valid),
        .pick_ch     (pick_ch)
    );

    assign pick_reason = pend_q[pick_ch];

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid  <= 1'b0;
            grant_ch     <= '0;
            grant_reason <= '0;
        end else begin
            grant_valid  <= pick_valid;
            grant_ch     <= pick_valid ? pick_ch : '0;
            grant_reason <= pick_valid ? pick_reason : '0;
        end
    end

endmodule

// File: rtl/sched_checker.sv
module sched_checker
    import sched_pkg::*;
#(
    parameter int N_CH = NCH,
    localparam int CW  = $clog2(N_CH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      engine_idle,
    input  logic                      grant_valid,
    input  logic [CW-1:0]             grant_ch,
    input  logic [NSRC-1:0]           grant_reason,
    input  logic [N_CH-1:0][1:0]      prio_q,
    input  logic [N_CH-1:0][NSRC-1:0] pend_q,
    input  logic [N_CH-1:0][NSRC-1:0] new_req
);

    logic [N_CH-1:0][1:0]      prio_d;
    logic [N_CH-1:0][NSRC-1:0] pend_d;
    logic [N_CH-1:0][NSRC-1:0] new_d;
    logic                      idle_d;
    logic                      lower_same;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_d <= '0;
            pend_d <= '0;
            new_d  <= '0;
            idle_d <= 1'b0;
        end else begin
            prio_d <= prio_q;
            pend_d <= pend_q;
            new_d  <= new_req;
            idle_d <= engine_idle;
        end
    end

    always_comb begin
        lower_same = 1'b0;
        for (int c = 0; c < N_CH; c++)
            if ((CW'(c) < grant_ch) && (prio_d[c] == prio_d[grant_ch]) && (pend_d[c] != '0))
                lower_same = 1'b1;
    end

    assert_idle_gate_R2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> idle_d);

    assert_no_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (prio_d[grant_ch] != PRIO_OFF));

    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !lower_same);

    assert_reason_match_R6: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((grant_reason != '0) && (grant_reason == pend_d[grant_ch])));

    assert_served_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((pend_q[grant_ch] & grant_reason & ~new_d[grant_ch]) == '0));

endmodule

bind svc_sched sched_checker #(.N_CH(N_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .engine_idle  (engine_idle),
    .grant_valid  (grant_valid),
    .grant_ch     (grant_ch),
    .grant_reason (grant_reason),
    .prio_q       (prio_q),
    .pend_q       (pend_q),
    .new_req      (new_req)
);

// File: tb/sim_svc_sched.sv
`timescale 1ns/100ps
module sim_svc_sched;

    logic        clk = 1'b0;
    logic        rst;
    logic        prio_we;
    logic [3:0]  prio_ch;
    logic [1:0]  prio_val;
    logic        hreq_we;
    logic [3:0]  hreq_ch;
    logic [15:0] link_set, match_set, capture_set;
    logic        engine_idle;
    logic        grant_valid;
    logic [3:0]  grant_ch;
    logic [3:0]  grant_reason;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    svc_sched u0 (
        .clk(clk), .rst(rst),
        .prio_we(prio_we), .prio_ch(prio_ch), .prio_val(prio_val),
        .hreq_we(hreq_we), .hreq_ch(hreq_ch),
        .link_set(link_set), .match_set(match_set), .capture_set(capture_set),
        .engine_idle(engine_idle),
        .grant_valid(grant_valid), .grant_ch(grant_ch), .grant_reason(grant_reason)
    );

    // reason bits: 0 host, 1 link, 2 match, 3 capture
    localparam logic [7:0] BURST_EXP [5] = '{
        {4'd2,  4'b1000},   // slot H
        {4'd7,  4'b0010},   // slot M
        {4'd5,  4'b0100},   // slot H
        {4'd9,  4'b1001},   // slot L: host + capture together
        {4'd12, 4'b0100}    // H empty, skipped to M
    };

    task automatic chk_grant(input string req, input logic [3:0] ch, input logic [3:0] rs);
        n_run++;
        if (grant_valid !== 1'b1 || grant_ch !== ch || grant_reason !== rs) begin
            n_fail++;
            $display("FAIL %s: got v=%0b ch=%0d rs=%b, expected v=1 ch=%0d rs=%b",
                     req, grant_valid, grant_ch, grant_reason, ch, rs);
        end
    endtask

    task automatic chk_none(input string req);
        n_run++;
        if (grant_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: got v=%0b ch=%0d, expected v=0", req, grant_valid, grant_ch);
        end
    endtask

    task automatic set_prio(input int ch, input logic [1:0] p);
        prio_we = 1'b1; prio_ch = 4'(ch); prio_val = p;
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    task automatic host_req(input int ch);
        hreq_we = 1'b1; hreq_ch = 4'(ch);
        @(negedge clk);
        hreq_we = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] l, input logic [15:0] m, input logic [15:0] c);
        link_set = l; match_set = m; capture_set = c;
        @(negedge clk);
        link_set = '0; match_set = '0; capture_set = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; prio_we = 0; prio_ch = 0; prio_val = 0; hreq_we = 0; hreq_ch = 0;
        link_set = 0; match_set = 0; capture_set = 0; engine_idle = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_none("R1 reset state");

        // R1: priorities come out of reset disabled
        engine_idle = 1'b1;
        pulse(16'h0000, 16'h0001, 16'h0000);
        repeat (3) begin @(negedge clk); chk_none("R1 default priority off"); end
        engine_idle = 1'b0;

        set_prio(2, 2'b11); set_prio(5, 2'b11); set_prio(7, 2'b10);
        set_prio(9, 2'b01); set_prio(12, 2'b10);

        // R3: disabled channel 14 never wins
        engine_idle = 1'b1;
        pulse(16'h0000, 16'h0000, 16'h4000);
        repeat (3) begin @(negedge clk); chk_none("R3 disabled channel"); end
        engine_idle = 1'b0;

        // burst of mixed requests while the engine is busy
        hreq_we = 1'b1; hreq_ch = 4'd9;
        pulse(16'h0080, 16'h1020, 16'h0204);
        hreq_we = 1'b0;
        repeat (3) begin @(negedge clk); chk_none("R2 engine busy holds requests"); end

        engine_idle = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk_grant("R4 R6 slot sequence", BURST_EXP[i][7:4], BURST_EXP[i][3:0]);
        end
        repeat (2) begin @(negedge clk); chk_none("R3 only disabled left"); end
        engine_idle = 1'b0;

        // enable 14 as low: scan skips H,H,M,H to reach L
        set_prio(14, 2'b01);
        engine_idle = 1'b1;
        @(negedge clk); chk_grant("R4 skip to low", 4'd14, 4'b1000);
        @(negedge clk); chk_none("R2 single pulse");
        engine_idle = 1'b0;

        // R7: capture arrives at the edge that grants the match
        pulse(16'h0000, 16'h0004, 16'h0000);
        engine_idle = 1'b1; capture_set = 16'h0004;
        @(negedge clk); capture_set = '0;
        chk_grant("R7 old reason only", 4'd2, 4'b0100);
        @(negedge clk); chk_grant("R7 new reason kept", 4'd2, 4'b1000);
        engine_idle = 1'b0;

        // R8: host write at the edge that grants the match
        pulse(16'h0000, 16'h0020, 16'h0000);
        engine_idle = 1'b1; hreq_we = 1'b1; hreq_ch = 4'd5;
        @(negedge clk); hreq_we = 1'b0;
        chk_grant("R8 match served first", 4'd5, 4'b0100);
        @(negedge clk); chk_grant("R8 host bit kept", 4'd5, 4'b0001);
        engine_idle = 1'b0;

        // R8: host bit persists through a long busy period
        host_req(9);
        repeat (6) begin @(negedge clk); chk_none("R8 host bit waits"); end
        engine_idle = 1'b1;
        @(negedge clk); chk_grant("R8 host bit served", 4'd9, 4'b0001);
        engine_idle = 1'b0;

        // R5: two middle channels, lowest first
        pulse(16'h1080, 16'h0000, 16'h0000);
        engine_idle = 1'b1;
        @(negedge clk); chk_grant("R5 lowest first", 4'd7, 4'b0010);
        @(negedge clk); chk_grant("R5 then higher", 4'd12, 4'b0010);
        engine_idle = 1'b0;

        // R4: low level gets its slot between high grants
        pulse(16'h02A4, 16'h0000, 16'h0000);
        engine_idle = 1'b1;
        @(negedge clk); chk_grant("R4 high slot", 4'd2, 4'b0010);
        @(negedge clk); chk_grant("R4 low slot", 4'd9, 4'b0010);
        @(negedge clk); chk_grant("R4 high slot again", 4'd5, 4'b0010);
        @(negedge clk); chk_grant("R4 middle slot", 4'd7, 4'b0010);
        @(negedge clk); chk_none("R2 nothing eligible");
        engine_idle = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule